// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-clock static memory, 32 bits wide, with a small parameterised depth. Every control and data input is captured on the rising clock edge. An access opens when either of two active-low address strobes is asserted while the chip is selected. That strobe loads the external address into a burst register. Each later cycle of the burst accesses an address that the block generates itself from a 2-bit count. The count advances only while the active-low advance input is asserted. The burst order is linear or interleaved, chosen by the order input at the start of the burst.

Writes are gated per byte lane. A common lane gate must be low for the individual lane enables to count, and a global write input writes all four lanes. Read data passes through an output register, so read data appears one edge after the access edge. An output enable gates the data output combinationally. A sleep input freezes all internal state while it is high.

Top module: `burst_sram`

## Requirements
- R1: After reset the output register holds zero, so with `oe_n` low `dq_o` reads 0 and `dq_drv_o` is 1.
- R2: An access is registered at clock edge N. A read access loads the output register at edge N+1, so its data is visible after that edge. Cycles without a read leave the output register unchanged.
- R3: With order low (linear), burst address bits [1:0] are the start bits plus the count, modulo 4. Bits above bit 1 stay at the start address.
- R4: With order high (interleaved), burst address bits [1:0] are the start bits XOR the count. The order is taken from the order input at the strobe edge and holds for the whole burst.
- R5: In a burst cycle without a strobe, the count increments when `adv_n` is low. When `adv_n` is high, the count holds and the same address is accessed again.
- R6: Either strobe, asserted while selected, loads the external address, clears the count to 0 and starts an access. This applies in the middle of a running burst too.
- R7: A cycle started by `cpu_stb_n` is always a read, even when write inputs are asserted or `ctl_stb_n` is asserted in the same cycle. Write inputs take effect from the next burst cycle.
- R8: Lane k covers data bits [8k+7:8k]. The lane is written when `lane_wr_n[k]` and `lane_gate_n` are both low. When `lane_gate_n` is high the lane enables are ignored, and a cycle with no lane enabled is a read.
- R9: With `all_wr_n` low, all four lanes are written whatever `lane_gate_n` and `lane_wr_n` are.
- R10: The chip counts as selected only when `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. A strobe while not selected makes no access and ends the burst. Cycles after it make no access until the next selected strobe.
- R11: With `oe_n` high, `dq_o` is 0 and `dq_drv_o` is 0. With `oe_n` low, `dq_o` shows the output register. Both respond without a clock edge.
- R12: While `sleep_i` is high, clock edges change nothing: no write, no count change and no output-register load. A pending access resumes when `sleep_i` returns low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | DATA_W | Write data |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| cpu_stb_n | input | 1 | Processor-side address strobe (read start), active low |
| ctl_stb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| lane_gate_n | input | 1 | Common gate for the lane enables, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep_i | input | 1 | Sleep: high freezes the block |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| dq_o | output | DATA_W | Read data, zero when not driven |
| dq_drv_o | output | 1 | High when the data output is being driven |

## Verification
The bench builds the block with its defaults: a 6-bit address (64 words) and 32-bit data in four lanes. This lets every burst stay inside one aligned group of four words, whose contents the bench sets before reading. Bursts that start mid-group reach the wrap from word 3 to word 0 in linear order, and all four XOR patterns in interleaved order. With four lanes, one partial write leaves alternate bytes old and new, so a swapped or ignored lane shows up directly in the read-back word.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  // low two address bits for burst step cnt from start bits st
  function automatic logic [1:0] burst_low(burst_ord_e ord, logic [1:0] st, logic [1:0] cnt);
    logic [1:0] r;
    if (ord == ORD_INTERLEAVE) r = st ^ cnt;
    else                       r = st + cnt;
    return r;
  endfunction

endpackage

// File: rtl/sbs_rst_sync.sv
module sbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/sbs_lane_decode.sv
module sbs_lane_decode #(
  parameter int LANES = 4
) (
  input  logic             all_wr_n,
  input  logic             lane_gate_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] wr_lanes
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_lanes[g] = ~all_wr_n | (~lane_gate_n & ~lane_wr_n[g]);
  end
endmodule

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              run,
  input  logic              sel,
  input  logic              start_cpu,
  input  logic              start_ctl,
  input  logic              adv,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wr_lanes,
  output logic              active_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [1:0]        cnt_q,
  output logic              acc_vld,
  output logic              acc_wr,
  output logic [LANES-1:0]  acc_lanes,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata
);
  logic              active_d;
  logic [ADDR_W-1:0] base_d;
  logic [1:0]        cnt_d;
  burst_ord_e        ord_q, ord_d;
  logic              vld_d, wr_d;
  logic [LANES-1:0]  lanes_d;
  logic [DATA_W-1:0] wdata_d;
  logic              any_wr;

  assign any_wr = |wr_lanes;

  always_comb begin
    active_d = active_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    ord_d    = ord_q;
    vld_d    = 1'b0;
    wr_d     = 1'b0;
    lanes_d  = '0;
    wdata_d  = acc_wdata;
    if (start_cpu || start_ctl) begin
      if (sel) begin
        active_d = 1'b1;
        base_d   = addr_i;
        cnt_d    = 2'd0;
        ord_d    = burst_ord_e'(order_i);
        vld_d    = 1'b1;
        // the processor strobe opens a read, whatever the write inputs say
        wr_d     = start_cpu ? 1'b0 : any_wr;
        lanes_d  = start_cpu ? '0 : wr_lanes;
        wdata_d  = wdata_i;
      end else begin
        active_d = 1'b0;
      end
    end else if (active_q) begin
      cnt_d   = adv ? cnt_q + 2'd1 : cnt_q;
      vld_d   = 1'b1;
      wr_d    = any_wr;
      lanes_d = wr_lanes;
      wdata_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      active_q  <= 1'b0;
      base_q    <= '0;
      cnt_q     <= 2'd0;
      ord_q     <= ORD_LINEAR;
      acc_vld   <= 1'b0;
      acc_wr    <= 1'b0;
      acc_lanes <= '0;
      acc_wdata <= '0;
    end else if (run) begin
      active_q  <= active_d;
      base_q    <= base_d;
      cnt_q     <= cnt_d;
      ord_q     <= ord_d;
      acc_vld   <= vld_d;
      acc_wr    <= wr_d;
      acc_lanes <= lanes_d;
      acc_wdata <= wdata_d;
    end
  end

  assign acc_addr = {base_q[ADDR_W-1:2], burst_low(ord_q, base_q[1:0], cnt_q)};
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              run,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [LANES-1:0]  acc_lanes,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] rd_word;
  logic              rd_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic       we;
    assign we = run & acc_vld & acc_wr & acc_lanes[g];
    always_ff @(posedge clk) begin
      if (we) mem[acc_addr] <= acc_wdata[g*8 +: 8];
    end
    assign rd_word[g*8 +: 8] = mem[acc_addr];
  end

  assign rd_en = run & acc_vld & ~acc_wr;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              cpu_stb_n,
  input  logic              ctl_stb_n,
  input  logic              adv_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              lane_gate_n,
  input  logic              all_wr_n,
  input  logic              order_i,
  input  logic              sleep_i,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_drv_o
);
  logic              srst_n;
  logic              run, sel;
  logic [LANES-1:0]  wr_lanes;
  logic              active_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              acc_vld, acc_wr;
  logic [LANES-1:0]  acc_lanes;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] rdata_q;

  assign run = ~sleep_i;
  assign sel = ~sel_a_n & sel_b & ~sel_c_n;

  sbs_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  sbs_lane_decode #(.LANES(LANES)) u_dec (
    .all_wr_n    (all_wr_n),
    .lane_gate_n (lane_gate_n),
    .lane_wr_n   (lane_wr_n),
    .wr_lanes    (wr_lanes)
  );

  sbs_burst_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_ctrl (
    .clk       (clk),
    .srst_n    (srst_n),
    .run       (run),
    .sel       (sel),
    .start_cpu (~cpu_stb_n),
    .start_ctl (~ctl_stb_n),
    .adv       (~adv_n),
    .order_i   (order_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wr_lanes  (wr_lanes),
    .active_q  (active_q),
    .base_q    (base_q),
    .cnt_q     (cnt_q),
    .acc_vld   (acc_vld),
    .acc_wr    (acc_wr),
    .acc_lanes (acc_lanes),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata)
  );

  sbs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_mem (
    .clk       (clk),
    .srst_n    (srst_n),
    .run       (run),
    .acc_vld   (acc_vld),
    .acc_wr    (acc_wr),
    .acc_lanes (acc_lanes),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .rdata_q   (rdata_q)
  );

  assign dq_o     = oe_n ? '0 : rdata_q;
  assign dq_drv_o = ~oe_n;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              srst_n,
  input logic              sleep_i,
  input logic              oe_n,
  input logic              cpu_stb_n,
  input logic              ctl_stb_n,
  input logic              adv_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              active_q,
  input logic [ADDR_W-1:0] base_q,
  input logic [1:0]        cnt_q,
  input logic              acc_vld,
  input logic              acc_wr,
  input logic [DATA_W-1:0] rdata_q,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_drv_o
);
  logic sel_c, strobe_c, cont_c;
  assign sel_c    = ~sel_a_n & sel_b & ~sel_c_n;
  assign strobe_c = ~cpu_stb_n | ~ctl_stb_n;
  assign cont_c   = ~sleep_i & ~strobe_c & active_q;

  a_r2_hold_without_read: assert property (@(posedge clk) disable iff (!srst_n)
    !(acc_vld && !acc_wr && !sleep_i) |=> $stable(rdata_q));

  a_r5_step: assert property (@(posedge clk) disable iff (!srst_n)
    (cont_c && !adv_n) |=> cnt_q == 2'($past(cnt_q) + 2'd1));

  a_r5_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (cont_c && adv_n) |=> $stable(cnt_q) && $stable(base_q));

  a_r6_load: assert property (@(posedge clk) disable iff (!srst_n)
    (!sleep_i && strobe_c && sel_c) |=> (cnt_q == 2'd0) && (base_q == $past(addr_i)) && acc_vld);

  a_r7_cpu_read: assert property (@(posedge clk) disable iff (!srst_n)
    (!sleep_i && !cpu_stb_n && sel_c) |=> !acc_wr);

  a_r10_deselect: assert property (@(posedge clk) disable iff (!srst_n)
    (!sleep_i && strobe_c && !sel_c) |=> !acc_vld && !active_q);

  a_r11_undriven: assert property (@(posedge clk) disable iff (!srst_n)
    oe_n |-> (dq_o == '0) && !dq_drv_o);

  a_r11_driven: assert property (@(posedge clk) disable iff (!srst_n)
    !oe_n |-> (dq_o == rdata_q) && dq_drv_o);

  a_r12_frozen: assert property (@(posedge clk) disable iff (!srst_n)
    sleep_i |=> $stable(rdata_q) && $stable(cnt_q) && $stable(base_q) && $stable(acc_vld));
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .sleep_i   (sleep_i),
  .oe_n      (oe_n),
  .cpu_stb_n (cpu_stb_n),
  .ctl_stb_n (ctl_stb_n),
  .adv_n     (adv_n),
  .sel_a_n   (sel_a_n),
  .sel_b     (sel_b),
  .sel_c_n   (sel_c_n),
  .addr_i    (addr_i),
  .active_q  (active_q),
  .base_q    (base_q),
  .cnt_q     (cnt_q),
  .acc_vld   (acc_vld),
  .acc_wr    (acc_wr),
  .rdata_q   (rdata_q),
  .dq_o      (dq_o),
  .dq_drv_o  (dq_drv_o)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic          sel_a_n, sel_b, sel_c_n;
  logic          cpu_stb_n, ctl_stb_n, adv_n;
  logic [3:0]    lane_wr_n;
  logic          lane_gate_n, all_wr_n, order_i, sleep_i, oe_n;
  logic [DW-1:0] dq_o;
  logic          dq_drv_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
    .lane_wr_n(lane_wr_n), .lane_gate_n(lane_gate_n), .all_wr_n(all_wr_n),
    .order_i(order_i), .sleep_i(sleep_i), .oe_n(oe_n),
    .dq_o(dq_o), .dq_drv_o(dq_drv_o)
  );

  // one row: inputs as asserted=1, then the dq value expected before they are applied
  typedef struct packed {
    logic        cpu, ctl, adv, sel, gall, gate;
    logic [3:0]  ln;
    logic        mode;
    logic [5:0]  a;
    logic [31:0] wd;
    logic        chk;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t mk(logic cpu, logic ctl, logic adv, logic sel, logic gall,
                              logic gate, logic [3:0] ln, logic mode, logic [5:0] a,
                              logic [31:0] wd, logic [31:0] exp, logic [7:0] req);
    vec_t v;
    v = '{cpu, ctl, adv, sel, gall, gate, ln, mode, a, wd, 1'b1, exp, req};
    return v;
  endfunction

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    mk(0,1,0,1,1,0,4'h0,0,6'h10,32'h11111111,32'h0,        8'd1),  // R1 write 0x10
    mk(0,0,1,1,1,0,4'h0,0,6'h00,32'h22222222,32'h0,        8'd1),  // R1 write 0x11
    mk(0,0,1,1,1,0,4'h0,0,6'h00,32'h33333333,32'h0,        8'd1),  // write 0x12
    mk(0,0,1,1,1,0,4'h0,0,6'h00,32'h44444444,32'h0,        8'd2),  // R2 write 0x13
    mk(0,0,0,1,0,0,4'h0,0,6'h00,32'h0,       32'h0,        8'd2),  // hold: read 0x13
    mk(1,0,0,1,0,0,4'h0,0,6'h12,32'h0,       32'h0,        8'd2),  // R3 linear from 0x12
    mk(0,0,1,1,0,0,4'h0,0,6'h00,32'h0,       32'h44444444, 8'd5),  // R5 hold re-read
    mk(0,0,1,1,0,0,4'h0,0,6'h00,32'h0,       32'h33333333, 8'd2),  // R2 two-edge latency
    mk(0,0,1,1,0,0,4'h0,0,6'h00,32'h0,       32'h44444444, 8'd3),
    mk(1,0,0,1,0,0,4'h0,1,6'h11,32'h0,       32'h11111111, 8'd3),  // R3 wrap 3->0
    mk(0,0,1,1,0,0,4'h0,0,6'h00,32'h0,       32'h22222222, 8'd3),  // R4 interleaved from 0x11
    mk(0,0,1,1,0,0,4'h0,0,6'h00,32'h0,       32'h22222222, 8'd6),  // R6 restart
    mk(0,0,1,1,0,0,4'h0,0,6'h00,32'h0,       32'h11111111, 8'd4),  // R4 1^1
    mk(0,0,0,1,0,0,4'h0,0,6'h00,32'h0,       32'h44444444, 8'd4),  // R4 1^2
    mk(0,1,0,1,0,1,4'h5,0,6'h10,32'hAABBCCDD,32'h33333333, 8'd4),  // R4 1^3; R8 lanes 0,2
    mk(0,1,0,1,0,0,4'hF,0,6'h11,32'hFFFFFFFF,32'h33333333, 8'd5),  // R8 gate off -> read
    mk(0,1,0,1,1,0,4'h0,0,6'h12,32'h5A5A5A5A,32'h33333333, 8'd8),  // R9 global write
    mk(1,0,0,1,1,0,4'h0,0,6'h12,32'h99999999,32'h22222222, 8'd8),  // R7 strobe cycle reads
    mk(0,0,1,1,1,0,4'h0,0,6'h00,32'h77777777,32'h22222222, 8'd9),  // R7 write next cycle 0x13
    mk(1,0,0,1,0,0,4'h0,0,6'h10,32'h0,       32'h5A5A5A5A, 8'd7),
    mk(1,0,0,1,0,0,4'h0,0,6'h13,32'h0,       32'h5A5A5A5A, 8'd7),
    mk(0,1,0,0,0,0,4'h0,0,6'h00,32'h0,       32'h11BB11DD, 8'd8),  // R10 strobe deselected
    mk(0,0,1,1,1,0,4'h0,0,6'h00,32'h0,       32'h77777777, 8'd7),  // R10 no access after
    mk(0,0,0,1,0,0,4'h0,0,6'h00,32'h0,       32'h77777777, 8'd10),
    mk(1,0,0,1,0,0,4'h0,0,6'h13,32'h0,       32'h77777777, 8'd10),
    mk(0,0,0,1,0,0,4'h0,0,6'h00,32'h0,       32'h77777777, 8'd10),
    mk(0,0,0,1,0,0,4'h0,0,6'h00,32'h0,       32'h77777777, 8'd10)
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cpu_stb_n   = ~v.cpu;
    ctl_stb_n   = ~v.ctl;
    adv_n       = ~v.adv;
    sel_a_n     = 1'b0;
    sel_b       = v.sel;
    sel_c_n     = 1'b0;
    all_wr_n    = ~v.gall;
    lane_gate_n = ~v.gate;
    lane_wr_n   = ~v.ln;
    order_i     = v.mode;
    addr_i      = v.a;
    wdata_i     = v.wd;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] frozen;
    apply(mk(0,0,0,1,0,0,4'h0,0,6'h0,32'h0,32'h0,8'd0));
    sleep_i = 1'b0;
    oe_n    = 1'b0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 dq after reset", dq_o, 32'h0);
    check("R1 drive after reset", {31'h0, dq_drv_o}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (TBL[i].chk) check($sformatf("R%0d row %0d", TBL[i].req, i), dq_o, TBL[i].exp);
      apply(TBL[i]);
    end

    // R12: sleep freezes the pipeline and blocks writes
    @(negedge clk); apply(mk(0,1,0,1,1,0,4'h0,0,6'h20,32'hCAFEF00D,32'h0,8'd0));
    @(negedge clk); apply(mk(0,0,1,1,1,0,4'h0,0,6'h00,32'h0BADC0DE,32'h0,8'd0));
    @(negedge clk); apply(mk(1,0,0,1,0,0,4'h0,0,6'h20,32'h0,32'h0,8'd0));
    @(negedge clk);
    frozen  = dq_o;
    sleep_i = 1'b1;
    apply(mk(0,1,1,1,1,0,4'h0,0,6'h21,32'hDEADBEEF,32'h0,8'd0));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R12 dq frozen in sleep", dq_o, frozen);
    end
    sleep_i = 1'b0;
    apply(mk(0,0,1,1,0,0,4'h0,0,6'h00,32'h0,32'h0,8'd0));
    @(negedge clk);
    check("R12 pending read resumes", dq_o, 32'hCAFEF00D);
    apply(mk(0,0,0,1,0,0,4'h0,0,6'h00,32'h0,32'h0,8'd0));
    @(negedge clk);
    check("R12 no write during sleep", dq_o, 32'h0BADC0DE);

    // R11: output enable acts without a clock edge
    #1 oe_n = 1'b1;
    #1 check("R11 dq undriven", dq_o, 32'h0);
    check("R11 drive low", {31'h0, dq_drv_o}, 32'h0);
    oe_n = 1'b0;
    #1 check("R11 dq driven", dq_o, 32'h0BADC0DE);
    check("R11 drive high", {31'h0, dq_drv_o}, 32'h1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule